// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a four-bit arithmetic and logic slice. A four-bit select code and a mode bit pick one of sixteen bitwise logic functions or one of sixteen add-type arithmetic expressions over two four-bit operands. In arithmetic mode the slice resolves every internal carry with a full lookahead network. It also exports a group propagate and a group generate term, which an outer carry network can use. A carry output lets several slices be chained by ripple to form wider words. An equality flag rises whenever the result is all ones. In the subtract setting with no carry applied, that flag means the two operands are equal.

Operands and results are active high. The carry input, the carry output, the group propagate and the group generate are active low. The outputs pass through one register stage when `REG_OUT` is 1, which is the default. When `REG_OUT` is 0 the slice is purely combinational. The register stage lets a test fixture sample all results on a clock edge.

Top module: `alu_slice`

## Requirements
- R1: While `rst_n` is low, the registered outputs hold `f`=0, `eq`=0, `cout_n`=1, `prop_n`=1 and `gen_n`=1. With `REG_OUT`=1, a change on any input shows at the outputs after the next rising clock edge and not before it.
- R2: With `mode`=1, `f` is a bitwise function of `a` and `b`, selected by `sel`. The codes are: 0000 NOT a, 0001 NOR, 0010 (NOT a) AND b, 0011 all zeros, 0100 NAND, 0101 NOT b, 0110 XOR, 0111 a AND (NOT b), 1000 (NOT a) OR b, 1001 XNOR, 1010 b, 1011 AND, 1100 all ones, 1101 a OR (NOT b), 1110 OR, 1111 a.
- R3: With `mode`=1, `cin_n` has no effect on `f`, and `cout_n` stays at 1.
- R4: With `mode`=0, `f` is the low four bits of X + Y + k, where k = 1 when `cin_n`=0 and k = 0 otherwise. X and Y depend on `sel` as follows. 0000 X=a, Y=0. 0001 a|b, 0. 0010 a|~b, 0. 0011 1111, 0. 0100 a, a&~b. 0101 a|b, a&~b. 0110 a, ~b (a minus b minus 1). 0111 1111, a&~b. 1000 a, a&b. 1001 a, b (add). 1010 a|~b, a&b. 1011 1111, a&b. 1100 a, a (doubling). 1101 a|b, a. 1110 a|~b, a. 1111 1111, a (a minus 1).
- R5: With `mode`=0, `cout_n` is the inverse of bit 4 of the five-bit sum X + Y + k. For code 0110 with `cin_n`=0, `f` is a minus b, and `cout_n`=0 exactly when a >= b (no borrow).
- R6: `prop_n` is the inverse of the AND over all bits of (X|Y). `gen_n` is the inverse of bit 4 of X + Y. Both ignore `cin_n` and `mode`.
- R7: `eq` is 1 exactly when `f` is 1111.
- R8: Four slices chained by feeding each `cout_n` into the next `cin_n` perform a 16-bit add (code 1001) and a 16-bit subtract (code 0110, `cin_n`=0). The last `cout_n` gives the carry, or the inverted borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | W | Operand A |
| b | input | W | Operand B |
| sel | input | 4 | Function select code |
| mode | input | 1 | 1 = logic functions, 0 = arithmetic |
| cin_n | input | 1 | Carry input, active low |
| f | output | W | Function result |
| cout_n | output | 1 | Carry output, active low |
| prop_n | output | 1 | Group propagate, active low |
| gen_n | output | 1 | Group generate, active low |
| eq | output | 1 | High when every result bit is one |

## Verification
The slice holds no state apart from its output register. A wrong per-bit term or a wrong lookahead product therefore shows on `f`, `cout_n`, `prop_n` or `gen_n` one clock after the input pattern that exposes it. The exhaustive sweep covers both modes, all sixteen codes, every operand pair and both carry levels. This means any such fault is caught on the first vector that reaches it. The ripple-chained tests then check that the carry out of one slice lands correctly in the next.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_LOGIC = 1'b1
  } alu_mode_e;

  // Per-bit term pair: wide term (propagate) and narrow term (generate).
  // The narrow term always implies the wide one.
  function automatic logic [1:0] bit_terms(logic [SEL_W-1:0] s, logic ai, logic bi);
    logic wide;
    logic narrow;
    wide   = ai | (s[0] & bi) | (s[1] & ~bi);
    narrow = (s[2] & ai & ~bi) | (s[3] & ai & bi);
    return {wide, narrow};
  endfunction

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import alu_slice_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     p,
  output logic [W-1:0]     g
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] t;
    assign t    = bit_terms(sel, a[i], b[i]);
    assign p[i] = t[1];
    assign g[i] = t[0];
  end

endmodule

// File: rtl/alu_carry_lookahead.sv
module alu_carry_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W-1:0] c,
  output logic         cout,
  output logic         grp_p,
  output logic         grp_g
);

  // Sum-of-products carry into bit n, built only from p, g and cin
  function automatic logic carry_into(int n, logic [W-1:0] pv, logic [W-1:0] gv, logic ci);
    logic acc;
    logic term;
    acc = ci;
    for (int k = 0; k < n; k++) acc = acc & pv[k];
    for (int j = 0; j < n; j++) begin
      term = gv[j];
      for (int k = j + 1; k < n; k++) term = term & pv[k];
      acc = acc | term;
    end
    return acc;
  endfunction

  always_comb begin
    for (int i = 0; i < W; i++) c[i] = carry_into(i, p, g, cin);
    grp_p = &p;
    grp_g = carry_into(W, p, g, 1'b0);
    cout  = grp_g | (grp_p & cin);
  end

endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage
  import alu_slice_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic [W-1:0] c,
  input  alu_mode_e    mode,
  output logic [W-1:0] f,
  output logic         eq
);

  logic [W-1:0] half;
  logic [W-1:0] c_eff;

  // Logic mode forces every internal carry to one, which inverts the half sum
  always_comb begin
    half  = p ^ g;
    c_eff = (mode == MODE_LOGIC) ? {W{1'b1}} : c;
    f     = half ^ c_eff;
    eq    = &f;
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int unsigned W       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  input  logic             mode,
  input  logic             cin_n,
  output logic [W-1:0]     f,
  output logic             cout_n,
  output logic             prop_n,
  output logic             gen_n,
  output logic             eq
);

  localparam int unsigned OUT_W = W + 4;

  alu_mode_e    mode_e;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_c;
  logic         carry_out;
  logic         grp_p;
  logic         grp_g;
  logic [W-1:0] f_d;
  logic         eq_d;
  logic         cout_n_d;
  logic [OUT_W-1:0] out_d;
  logic [OUT_W-1:0] out_q;

  assign mode_e = alu_mode_e'(mode);

  alu_bit_terms #(.W(W)) u_terms (
    .a   (a),
    .b   (b),
    .sel (sel),
    .p   (bit_p),
    .g   (bit_g)
  );

  alu_carry_lookahead #(.W(W)) u_cla (
    .p     (bit_p),
    .g     (bit_g),
    .cin   (~cin_n),
    .c     (bit_c),
    .cout  (carry_out),
    .grp_p (grp_p),
    .grp_g (grp_g)
  );

  alu_result_stage #(.W(W)) u_res (
    .p    (bit_p),
    .g    (bit_g),
    .c    (bit_c),
    .mode (mode_e),
    .f    (f_d),
    .eq   (eq_d)
  );

  always_comb begin
    cout_n_d = (mode_e == MODE_LOGIC) ? 1'b1 : ~carry_out;
    out_d    = {f_d, cout_n_d, ~grp_p, ~grp_g, eq_d};
  end

  if (REG_OUT) begin : g_reg
    // Reset pattern: f=0, cout_n=1, prop_n=1, gen_n=1, eq=0
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= {{W{1'b0}}, 1'b1, 1'b1, 1'b1, 1'b0};
      else        out_q <= out_d;
    end
  end else begin : g_comb
    assign out_q = out_d;
  end

  assign {f, cout_n, prop_n, gen_n, eq} = out_q;

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int unsigned W       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   sel,
  input logic         mode,
  input logic         cin_n,
  input logic [W-1:0] f,
  input logic         cout_n,
  input logic         prop_n,
  input logic         gen_n,
  input logic         eq
);

  logic [W-1:0] s_a;
  logic [W-1:0] s_b;
  logic [3:0]   s_sel;
  logic         s_mode;
  logic         s_cin_n;
  logic         vld;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk) begin
      s_a     <= a;
      s_b     <= b;
      s_sel   <= sel;
      s_mode  <= mode;
      s_cin_n <= cin_n;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= 1'b0;
      else        vld <= 1'b1;
    end
  end else begin : g_live
    assign s_a     = a;
    assign s_b     = b;
    assign s_sel   = sel;
    assign s_mode  = mode;
    assign s_cin_n = cin_n;
    assign vld     = rst_n;
  end

  AST_EQ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    eq == (&f)); // R7

  AST_LOGIC_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && s_mode) |-> cout_n); // R3

  AST_LOGIC_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && s_mode && s_sel == 4'b0110) |-> (f == (s_a ^ s_b))); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !s_mode && s_sel == 4'b1001) |->
      ({~cout_n, f} == ({1'b0, s_a} + {1'b0, s_b} + {{W{1'b0}}, ~s_cin_n}))); // R4

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !s_mode && s_sel == 4'b0110 && !s_cin_n) |-> (cout_n == (s_a < s_b))); // R5

  AST_PROP_ALL_ONES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && s_sel == 4'b0011) |-> (!prop_n && gen_n)); // R6

endmodule

bind alu_slice alu_slice_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a      (a),
  .b      (b),
  .sel    (sel),
  .mode   (mode),
  .cin_n  (cin_n),
  .f      (f),
  .cout_n (cout_n),
  .prop_n (prop_n),
  .gen_n  (gen_n),
  .eq     (eq)
);

// File: tb/alu_slice_tb.sv
module alu_slice_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] a, b, sel;
  logic       mode, cin_n;
  logic [3:0] f;
  logic       cout_n, prop_n, gen_n, eq;

  int n_chk;
  int n_bad;
  bit done;

  alu_slice #(.W(4), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sel(sel), .mode(mode), .cin_n(cin_n),
    .f(f), .cout_n(cout_n), .prop_n(prop_n), .gen_n(gen_n), .eq(eq)
  );

  // Four combinational slices chained by ripple
  logic [15:0] ch_a, ch_b, ch_f;
  logic [3:0]  ch_sel;
  logic [4:0]  ch_c;
  logic [3:0]  ch_p, ch_g, ch_e;

  for (genvar i = 0; i < 4; i++) begin : g_chain
    alu_slice #(.W(4), .REG_OUT(1'b0)) u_slice (
      .clk(clk), .rst_n(rst_n), .a(ch_a[4*i +: 4]), .b(ch_b[4*i +: 4]), .sel(ch_sel),
      .mode(1'b0), .cin_n(ch_c[i]), .f(ch_f[4*i +: 4]), .cout_n(ch_c[i+1]),
      .prop_n(ch_p[i]), .gen_n(ch_g[i]), .eq(ch_e[i])
    );
  end

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference from the requirement tables: returns {f, cout_n, prop_n, gen_n, eq}
  function automatic logic [7:0] ref_model(logic m, logic [3:0] s, logic [3:0] x_a,
                                           logic [3:0] x_b, logic ci_n);
    logic [3:0] x, y, r;
    logic [4:0] sum, gsum;
    logic       co_n;
    case (s)
      4'b0000: begin x = x_a;          y = 4'h0;         end
      4'b0001: begin x = x_a | x_b;    y = 4'h0;         end
      4'b0010: begin x = x_a | ~x_b;   y = 4'h0;         end
      4'b0011: begin x = 4'hF;         y = 4'h0;         end
      4'b0100: begin x = x_a;          y = x_a & ~x_b;   end
      4'b0101: begin x = x_a | x_b;    y = x_a & ~x_b;   end
      4'b0110: begin x = x_a;          y = ~x_b;         end
      4'b0111: begin x = 4'hF;         y = x_a & ~x_b;   end
      4'b1000: begin x = x_a;          y = x_a & x_b;    end
      4'b1001: begin x = x_a;          y = x_b;          end
      4'b1010: begin x = x_a | ~x_b;   y = x_a & x_b;    end
      4'b1011: begin x = 4'hF;         y = x_a & x_b;    end
      4'b1100: begin x = x_a;          y = x_a;          end
      4'b1101: begin x = x_a | x_b;    y = x_a;          end
      4'b1110: begin x = x_a | ~x_b;   y = x_a;          end
      default: begin x = 4'hF;         y = x_a;          end
    endcase
    sum  = {1'b0, x} + {1'b0, y} + {4'h0, ~ci_n};
    gsum = {1'b0, x} + {1'b0, y};
    if (m) begin
      case (s)
        4'b0000: r = ~x_a;
        4'b0001: r = ~(x_a | x_b);
        4'b0010: r = ~x_a & x_b;
        4'b0011: r = 4'h0;
        4'b0100: r = ~(x_a & x_b);
        4'b0101: r = ~x_b;
        4'b0110: r = x_a ^ x_b;
        4'b0111: r = x_a & ~x_b;
        4'b1000: r = ~x_a | x_b;
        4'b1001: r = ~(x_a ^ x_b);
        4'b1010: r = x_b;
        4'b1011: r = x_a & x_b;
        4'b1100: r = 4'hF;
        4'b1101: r = x_a | ~x_b;
        4'b1110: r = x_a | x_b;
        default: r = x_a;
      endcase
      co_n = 1'b1;
    end else begin
      r    = sum[3:0];
      co_n = ~sum[4];
    end
    return {r, co_n, ~(&(x | y)), ~gsum[4], &r};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic m, logic [3:0] s, logic [3:0] va, logic [3:0] vb, logic ci_n);
    @(negedge clk);
    mode = m; sel = s; a = va; b = vb; cin_n = ci_n;
    @(negedge clk);
  endtask

  // {mode, sel, a, b, cin_n, f, cout_n, eq}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 4'b1001, 4'h3, 4'h4, 1'b1, 4'h7, 1'b1, 1'b0},  // R4 add
    {1'b0, 4'b1001, 4'h9, 4'h8, 1'b0, 4'h2, 1'b0, 1'b0},  // R5 add with carry out
    {1'b0, 4'b0110, 4'h5, 4'h5, 1'b1, 4'hF, 1'b1, 1'b1},  // R7 equal operands
    {1'b0, 4'b0110, 4'h5, 4'h5, 1'b0, 4'h0, 1'b0, 1'b0},  // R5 no borrow
    {1'b0, 4'b0110, 4'h3, 4'h7, 1'b0, 4'hC, 1'b1, 1'b0},  // R5 borrow
    {1'b0, 4'b1100, 4'h9, 4'h0, 1'b1, 4'h2, 1'b0, 1'b0},  // R4 doubling
    {1'b0, 4'b0000, 4'h6, 4'hF, 1'b0, 4'h7, 1'b1, 1'b0},  // R4 a plus carry
    {1'b0, 4'b1111, 4'h0, 4'h0, 1'b1, 4'hF, 1'b1, 1'b1},  // R4 a minus 1
    {1'b0, 4'b1111, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0},  // R4 a minus 1 plus carry
    {1'b1, 4'b0110, 4'hC, 4'hA, 1'b0, 4'h6, 1'b1, 1'b0},  // R2 xor, R3 carry ignored
    {1'b1, 4'b1011, 4'hC, 4'hA, 1'b1, 4'h8, 1'b1, 1'b0},  // R2 and
    {1'b1, 4'b1110, 4'hC, 4'hA, 1'b0, 4'hE, 1'b1, 1'b0},  // R2 or
    {1'b1, 4'b1100, 4'h0, 4'h0, 1'b0, 4'hF, 1'b1, 1'b1},  // R2 ones, R7
    {1'b1, 4'b0000, 4'h3, 4'h5, 1'b1, 4'hC, 1'b1, 1'b0}   // R2 not a
  };

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; a = 4'h0; b = 4'h0; sel = 4'h0; mode = 1'b0; cin_n = 1'b1;
    ch_a = 16'h0; ch_b = 16'h0; ch_sel = 4'b1001; ch_c[0] = 1'b1;

    // R1: reset values hold even with live inputs
    repeat (2) @(negedge clk);
    a = 4'hF; b = 4'hF; sel = 4'b1001; cin_n = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {24'h0, f, cout_n, prop_n, gen_n, eq}, {24'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0});
    @(negedge clk) rst_n = 1'b1;

    // R1: one-cycle latency
    @(negedge clk);
    mode = 1'b0; sel = 4'b1001; a = 4'h2; b = 4'h3; cin_n = 1'b1;
    @(negedge clk);
    check("R1 first result", {28'h0, f}, 32'h5);
    a = 4'h7;
    #1;
    check("R1 holds before edge", {28'h0, f}, 32'h5);
    @(negedge clk);
    check("R1 after edge", {28'h0, f}, 32'hA);

    // Directed vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
      check($sformatf("vector %0d R2/R4/R5/R7", i), {26'h0, f, cout_n, eq}, {26'h0, VEC[i][5:0]});
    end

    // Exhaustive sweep: R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int va = 0; va < 16; va++)
          for (int vb = 0; vb < 16; vb++)
            for (int ci = 0; ci < 2; ci++) begin
              drive(m[0], s[3:0], va[3:0], vb[3:0], ci[0]);
              check(m ? "R2/R3/R6/R7 sweep" : "R4/R5/R6/R7 sweep",
                    {24'h0, f, cout_n, prop_n, gen_n, eq},
                    {24'h0, ref_model(m[0], s[3:0], va[3:0], vb[3:0], ci[0])});
            end

    // R8: 16-bit ripple add and subtract
    @(negedge clk);
    ch_sel = 4'b1001; ch_c[0] = 1'b1; ch_a = 16'h1234; ch_b = 16'h0FFF;
    #1 check("R8 add", {15'h0, ~ch_c[4], ch_f}, {15'h0, 17'h02233});
    ch_a = 16'hFFFF; ch_b = 16'h0001;
    #1 check("R8 add carry out", {15'h0, ~ch_c[4], ch_f}, {15'h0, 17'h10000});
    ch_sel = 4'b0110; ch_c[0] = 1'b0; ch_a = 16'h8000; ch_b = 16'h0001;
    #1 check("R8 sub no borrow", {15'h0, ch_c[4], ch_f}, {15'h0, 17'h07FFF});
    ch_a = 16'h0005; ch_b = 16'h0009;
    #1 check("R8 sub borrow", {15'h0, ch_c[4], ch_f}, {15'h0, 17'h1FFFC});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule